// File: doc/BRIEF.md
# Primary Interrupt Status Aggregator

This block gathers the pending-interrupt flags of up to eight secondary interrupt modules and presents them to two independent host masters. Each master owns one active-low interrupt output and one byte-wide status register. Bit n of a master's status register shows whether secondary module n is pending on that master's line. A master reads this register to find out which secondary modules it must service.

All pending inputs pass through a two-flop synchronizer before they are combined. Some secondary modules have only one interrupt output, and their pending flag is shown on both lines. Slots with no module fitted always read zero. A test register lets software force status bits on both lines at once, which allows the interrupt path to be exercised without any secondary module. Status reads are side-effect free, because pending state is cleared inside the secondary modules.

Top module: `prim_irq_agg`

## Requirements
- R1: Register offset 0x01 returns line-0 status. Bit n is 1 two clock edges after `pend_l0_i[n]` goes high, for any populated slot n. Bit n returns to 0 two edges after the input falls.
- R2: Register offset 0x02 returns line-1 status in the same way from `pend_l1_i`. It is independent of line 0.
- R3: `irq1_no` (line 0) and `irq2_no` (line 1) are low one clock edge after the matching status register becomes non-zero. They are high one edge after it becomes zero.
- R4: For every slot whose bit is set in `SINGLE_MASK` (default 8'h40, slot 6), the line-0 pending input drives the status bit on both lines. The line-1 input of that slot is ignored.
- R5: For every slot whose bit is clear in `POP_MASK` (default 8'h7F, so slot 7 is empty), the status bit reads 0 on both lines. That slot never drives an output low.
- R6: A write to offset 0x03 stores the written value, masked to populated slots. Each stored 1 forces the matching status bit on both lines from the next edge onward. Writing 0 removes the force. Offset 0x03 reads back the stored value.
- R7: Reading a status register does not change any status bit. Two back-to-back reads return the same value.
- R8: A read of any offset other than 0x01, 0x02 and 0x03 returns 0x00. A write to any offset other than 0x03 has no effect.
- R9: After reset, both status registers and the test register read 0x00, and both interrupt outputs are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pend_l0_i | input | 8 | Per-slot pending flags for line 0 (asynchronous) |
| pend_l1_i | input | 8 | Per-slot pending flags for line 1 (asynchronous) |
| addr_i | input | 8 | Register byte offset for reads and writes |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| irq1_no | output | 1 | Line-0 interrupt, active low |
| irq2_no | output | 1 | Line-1 interrupt, active low |

## Verification
A change on a pending input reaches the status registers after two rising edges, because of the two synchronizer flops. It reaches the interrupt outputs after three edges, because the output pins are also registered. A test-register write shows in status after one edge and on the pins after two. The bench drives every stimulus on a falling edge and counts the rising edges explicitly. It checks status and pins shortly after the edge on which each result is due. It also checks one edge earlier, to confirm that a result does not arrive too soon.

// File: rtl/prim_irq_agg_pkg.sv
package prim_irq_agg_pkg;
  localparam int unsigned NUM_LINES = 2;
  localparam logic [7:0] OFS_STAT_L0 = 8'h01;
  localparam logic [7:0] OFS_STAT_L1 = 8'h02;
  localparam logic [7:0] OFS_FORCE   = 8'h03;
endpackage

// File: rtl/prim_irq_agg_sync.sv
module prim_irq_agg_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/prim_irq_agg_line.sv
module prim_irq_agg_line #(
  parameter int unsigned W   = 8,
  parameter logic [W-1:0] POP = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pend_i,
  input  logic [W-1:0] force_i,
  output logic [W-1:0] stat_o,
  output logic         irq_no
);
  assign stat_o = (pend_i | force_i) & POP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_no <= 1'b1;
    else         irq_no <= ~(|stat_o);
  end

  // R3
  irq_assert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|stat_o) |=> !irq_no);
  // R3
  irq_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o == '0) |=> irq_no);
endmodule

// File: rtl/prim_irq_agg.sv
module prim_irq_agg
  import prim_irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [NUM_SRC-1:0] POP_MASK    = 8'h7F,
  parameter logic [NUM_SRC-1:0] SINGLE_MASK = 8'h40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] pend_l0_i,
  input  logic [NUM_SRC-1:0] pend_l1_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               irq1_no,
  output logic               irq2_no
);
  localparam logic [ADDR_W-1:0] A_L0 = ADDR_W'(OFS_STAT_L0);
  localparam logic [ADDR_W-1:0] A_L1 = ADDR_W'(OFS_STAT_L1);
  localparam logic [ADDR_W-1:0] A_FR = ADDR_W'(OFS_FORCE);

  logic [NUM_SRC-1:0] pend_raw [NUM_LINES];
  logic [NUM_SRC-1:0] pend_syn [NUM_LINES];
  logic [NUM_SRC-1:0] pend_rt  [NUM_LINES];
  logic [NUM_SRC-1:0] stat     [NUM_LINES];
  logic [NUM_LINES-1:0] irq_n;
  logic [NUM_SRC-1:0] force_q;

  assign pend_raw[0] = pend_l0_i;
  assign pend_raw[1] = pend_l1_i;

  // single-output modules feed both lines from the line-0 flag
  assign pend_rt[0] = pend_syn[0];
  assign pend_rt[1] = (pend_syn[1] & ~SINGLE_MASK) | (pend_syn[0] & SINGLE_MASK);

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    prim_irq_agg_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pend_raw[l]),
      .q_o   (pend_syn[l])
    );
    prim_irq_agg_line #(.W(NUM_SRC), .POP(POP_MASK)) u_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pend_i (pend_rt[l]),
      .force_i(force_q),
      .stat_o (stat[l]),
      .irq_no (irq_n[l])
    );
  end

  assign irq1_no = irq_n[0];
  assign irq2_no = irq_n[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          force_q <= '0;
    else if (wr_en_i && addr_i == A_FR)   force_q <= wdata_i & POP_MASK;
  end

  always_comb begin
    unique case (addr_i)
      A_L0:    rdata_o = stat[0];
      A_L1:    rdata_o = stat[1];
      A_FR:    rdata_o = force_q;
      default: rdata_o = '0;
    endcase
  end

  // R4
  mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat[0] ^ stat[1]) & SINGLE_MASK) == '0);
  // R5
  unpop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~POP_MASK) == '0);
  // R6
  force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat[0] & force_q) == force_q) && ((stat[1] & force_q) == force_q));
  // R8
  undecoded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != A_L0 && addr_i != A_L1 && addr_i != A_FR) |-> rdata_o == '0);
  // R6
  force_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_FR) |=> force_q == ($past(wdata_i) & POP_MASK));
endmodule

// File: tb/prim_irq_agg_bench.sv
`timescale 1ns/1ps
module prim_irq_agg_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] pend0 = 0, pend1 = 0, addr = 0, wdata = 0, rdata;
  logic       wr_en = 0, irq1_n, irq2_n;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  prim_irq_agg u_prim_irq_agg (
    .clk_i(clk), .rst_ni(rst_n), .pend_l0_i(pend0), .pend_l1_i(pend1),
    .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata),
    .irq1_no(irq1_n), .irq2_no(irq2_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d); chk(req, d, exp);
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic drive(input logic [7:0] p0, input logic [7:0] p1);
    @(negedge clk); pend0 = p0; pend1 = p1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #2; wr_en = 0;
  endtask

  task automatic t_reset;
    rdchk("R9", 8'h01, 8'h00); rdchk("R9", 8'h02, 8'h00); rdchk("R9", 8'h03, 8'h00);
    chk("R9", {7'd0, irq1_n}, 8'h01); chk("R9", {7'd0, irq2_n}, 8'h01);
  endtask

  task automatic t_line0;
    drive(8'h05, 8'h00);
    edges(1); rdchk("R1 early", 8'h01, 8'h00);
    edges(1); rdchk("R1", 8'h01, 8'h05); rdchk("R2", 8'h02, 8'h00);
    chk("R3 early", {7'd0, irq1_n}, 8'h01);
    edges(1); chk("R3", {7'd0, irq1_n}, 8'h00); chk("R3", {7'd0, irq2_n}, 8'h01);
    drive(8'h00, 8'h00); edges(2); rdchk("R1 fall", 8'h01, 8'h00);
    edges(1); chk("R3 release", {7'd0, irq1_n}, 8'h01);
  endtask

  task automatic t_line1;
    drive(8'h00, 8'h12); edges(2);
    rdchk("R2", 8'h02, 8'h12); rdchk("R1", 8'h01, 8'h00);
    edges(1); chk("R3", {7'd0, irq2_n}, 8'h00); chk("R3", {7'd0, irq1_n}, 8'h01);
    drive(8'h21, 8'h0A); edges(2);
    rdchk("R1", 8'h01, 8'h21); rdchk("R2", 8'h02, 8'h0A);
    drive(8'h00, 8'h00); edges(3);
  endtask

  task automatic t_mirror;
    drive(8'h40, 8'h00); edges(2);
    rdchk("R4", 8'h01, 8'h40); rdchk("R4", 8'h02, 8'h40);
    edges(1); chk("R4", {6'd0, irq1_n, irq2_n}, 8'h00);
    drive(8'h00, 8'h40); edges(3);
    rdchk("R4 ignore", 8'h02, 8'h00); chk("R4 ignore", {7'd0, irq2_n}, 8'h01);
    drive(8'h00, 8'h00); edges(3);
  endtask

  task automatic t_unpop;
    drive(8'h80, 8'h80); edges(3);
    rdchk("R5", 8'h01, 8'h00); rdchk("R5", 8'h02, 8'h00);
    chk("R5", {6'd0, irq1_n, irq2_n}, 8'h03);
    drive(8'h00, 8'h00); edges(2);
  endtask

  task automatic t_force;
    wr(8'h03, 8'h21);
    rdchk("R6", 8'h03, 8'h21); rdchk("R6", 8'h01, 8'h21); rdchk("R6", 8'h02, 8'h21);
    chk("R6 early", {7'd0, irq1_n}, 8'h01);
    edges(1); chk("R6", {6'd0, irq1_n, irq2_n}, 8'h00);
    wr(8'h03, 8'hFF); rdchk("R6 mask", 8'h03, 8'h7F); rdchk("R5", 8'h01, 8'h7F);
    wr(8'h03, 8'h00); rdchk("R6 clear", 8'h01, 8'h00); rdchk("R6 clear", 8'h02, 8'h00);
    edges(1); chk("R6 clear", {6'd0, irq1_n, irq2_n}, 8'h03);
  endtask

  task automatic t_noclear;
    logic [7:0] a, b;
    drive(8'h03, 8'h00); edges(2);
    rd(8'h01, a); @(negedge clk); rd(8'h01, b);
    chk("R7", a, 8'h03); chk("R7", b, 8'h03);
    drive(8'h00, 8'h00); edges(3);
  endtask

  task automatic t_undec;
    rdchk("R8", 8'h00, 8'h00); rdchk("R8", 8'h04, 8'h00); rdchk("R8", 8'hFF, 8'h00);
    wr(8'h01, 8'hFF); wr(8'h02, 8'hFF); wr(8'h83, 8'hFF); edges(1);
    rdchk("R8", 8'h01, 8'h00); rdchk("R8", 8'h02, 8'h00); rdchk("R8", 8'h03, 8'h00);
    chk("R8", {6'd0, irq1_n, irq2_n}, 8'h03);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1;
    t_line0(); t_line1(); t_mirror(); t_unpop(); t_force(); t_noclear(); t_undec();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); n_chk++; n_fail++; $display("FAIL watchdog expired"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule